// File: doc/BRIEF.md
# Clock Select Control Register Bank

This block holds the control state for a group of clock-select multiplexers. Each mux has one configuration word with a select field and a gate bit. Next to each configuration word sit two alias addresses. Writing ones to the set alias turns those bits on. Writing ones to the clear alias turns them off. Several agents can therefore change one mux without reading the word back first, and none of them can undo another's change. A configuration word can also be written directly at its base address, for older software.

A mux is built in one of two forms. A staged mux keeps its active select output unchanged after a configuration write. The new value reaches the output only when software writes that mux's bit in a shared update register. A direct mux copies every change of its select field to the output at once. The gate bit drives a per-mux clock enable with inverted polarity. The register bus is a single-cycle write strobe with a read path that responds combinationally to the address.

Each staged mux holds a two-state commit machine. It is in ST_SYNCED when the active output matches the staged field. The transition *stage* moves it to ST_PENDING when a write makes the staged field differ from the active output. The transition *commit* moves it back to ST_SYNCED when that mux's update bit is written. A direct mux never leaves ST_SYNCED.

Top module: `clkmux_regbank`

## Requirements
- R1: After reset, every select field reads 0 and every gate bit reads 1. Each configuration word therefore reads 0x80, every clk_en is 0 and every sel_active field is 0.
- R2: Mux m has its base address at 4*m. A write there loads the select field from wdata[3:1] and the gate bit from wdata[7]. A read there returns the select field at bits [3:1] and the gate at bit 7, and every other bit reads 0.
- R3: A write to the set alias (address 4*m+1) sets exactly the select and gate bits that are one in wdata. Bits written as zero keep their value.
- R4: A write to the clear alias (address 4*m+2) clears exactly the select and gate bits that are one in wdata. Bits written as zero keep their value.
- R5: clk_en[m] is the inverse of the gate bit. Clearing bit 7 enables the clock and setting bit 7 disables it, and the select field is left unchanged.
- R6: Writing the update register (address 4*NUM_MUX) with bit m at one loads a staged mux's select field into sel_active on that clock edge. A zero in bit m leaves that mux's output unchanged.
- R7: For a staged mux (muxes 0 and 1 by default), sel_active holds its value through any number of configuration writes until the update bit of that mux is written.
- R8: For a direct mux (muxes 2 and 3 by default), sel_active follows the select field on the same edge as the configuration write, and update-register writes have no effect on it.
- R9: Alias writes apply in issue order. A clear of the whole field followed by a set of an index gives exactly that index. The reverse order gives zero.
- R10: Reads of set, clear, reserved (4*m+3) and update addresses, and of any address above 4*NUM_MUX, return 0. The update bits are self-clearing.
- R11: A write to one mux's base, set or clear address leaves every other mux's configuration and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for bus_addr, combinational |
| sel_active | output | NUM_MUX*SEL_W (12) | Active select of each mux, mux m at [m*SEL_W +: SEL_W] |
| clk_en | output | NUM_MUX (4) | Clock enable of each mux, the inverse of its gate bit |

## Verification
The assertions check these rules on every cycle:
- A staged output stays stable unless an update arrives.
- An update loads exactly the previous staged value.
- A direct output always equals its field.
- Set and clear writes touch only the bits written as one.
- At most one register strobe fires per cycle.

The bench scenarios cover what needs an ordered sequence or an address-level view:
- clear-then-set against set-then-clear ordering
- zero reads of the alias and update addresses
- the masking of unimplemented bits on read-back
- isolation between muxes
- ignoring of update bits by direct muxes

// File: rtl/clkmux_pkg.sv
package clkmux_pkg;

    // Per-mux commit machine
    typedef enum logic {
        ST_SYNCED  = 1'b0,
        ST_PENDING = 1'b1
    } commit_state_e;

    // Low two address bits select the register kind within a mux slot
    localparam logic [1:0] KIND_BASE = 2'd0;
    localparam logic [1:0] KIND_SET  = 2'd1;
    localparam logic [1:0] KIND_CLR  = 2'd2;

endpackage

// File: rtl/clkmux_decode.sv
module clkmux_decode
    import clkmux_pkg::*;
#(
    parameter int NUM_MUX = 4,
    parameter int ADDR_W  = 5
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    output logic [NUM_MUX-1:0] base_wr,
    output logic [NUM_MUX-1:0] set_wr,
    output logic [NUM_MUX-1:0] clr_wr,
    output logic               upd_wr,
    output logic [NUM_MUX-1:0] rd_base
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int UPD_ADDR = NUM_MUX * 4;

    logic             in_slots;
    logic [IDX_W-1:0] slot;
    logic [1:0]       kind;

    assign in_slots = (addr < ADDR_W'(UPD_ADDR));
    assign slot     = addr[ADDR_W-1:2];
    assign kind     = addr[1:0];
    assign upd_wr   = wr && (addr == ADDR_W'(UPD_ADDR));

    for (genvar m = 0; m < NUM_MUX; m++) begin : g_slot
        logic hit;
        assign hit        = in_slots && (slot == IDX_W'(m));
        assign rd_base[m] = hit && (kind == KIND_BASE);
        assign base_wr[m] = wr && hit && (kind == KIND_BASE);
        assign set_wr[m]  = wr && hit && (kind == KIND_SET);
        assign clr_wr[m]  = wr && hit && (kind == KIND_CLR);
    end
endmodule

// File: rtl/clkmux_chan.sv
module clkmux_chan
    import clkmux_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int SEL_SHIFT = 1,
    parameter int GATE_POS  = 7,
    parameter int DATA_W    = 8,
    parameter bit STAGED    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              upd,
    input  logic [SEL_W-1:0]  wsel,
    input  logic              wgate,
    output logic [DATA_W-1:0] cfg_rd,
    output logic [SEL_W-1:0]  active,
    output logic              gate
);
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             gate_q, gate_d;
    logic [SEL_W-1:0] active_q, active_d;
    commit_state_e    state_q, state_d;

    // Staged configuration: base, set-alias and clear-alias writes
    always_comb begin
        sel_d  = sel_q;
        gate_d = gate_q;
        if (wr_base) begin
            sel_d  = wsel;
            gate_d = wgate;
        end else if (wr_set) begin
            sel_d  = sel_q | wsel;
            gate_d = gate_q | wgate;
        end else if (wr_clr) begin
            sel_d  = sel_q & ~wsel;
            gate_d = gate_q & ~wgate;
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_SYNCED;
            sel_q    <= '0;
            gate_q   <= 1'b1;
            active_q <= '0;
        end else begin
            state_q  <= state_d;
            sel_q    <= sel_d;
            gate_q   <= gate_d;
            active_q <= active_d;
        end
    end

    // Next state and output process
    always_comb begin
        state_d  = state_q;
        active_d = active_q;
        if (!STAGED) begin
            active_d = sel_d;
        end else begin
            unique case (state_q)
                ST_SYNCED: begin
                    if (sel_d != active_q) state_d = ST_PENDING;   // stage
                end
                ST_PENDING: begin
                    if (upd) begin                                  // commit
                        state_d  = ST_SYNCED;
                        active_d = sel_q;
                    end
                end
                default: state_d = ST_SYNCED;
            endcase
        end
    end

    always_comb begin
        cfg_rd                     = '0;
        cfg_rd[SEL_SHIFT +: SEL_W] = sel_q;
        cfg_rd[GATE_POS]           = gate_q;
    end

    assign active = active_q;
    assign gate   = gate_q;

    // R7: a staged output moves only on an update
    a_r7_hold_until_update: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGED && !upd) |=> $stable(active_q));

    // R6: an update loads the staged field as it stood before the edge
    a_r6_commit_loads_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGED && upd) |=> (active_q == $past(sel_q)));

    // R8: a direct output tracks its field
    a_r8_direct_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!STAGED) |-> (active_q == sel_q));

    // R2: a base write loads the field
    a_r2_base_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_base |=> (sel_q == $past(wsel)) && (gate_q == $past(wgate)));

    // R3: a set write raises the ones and keeps the rest
    a_r3_set_exact: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (sel_q == ($past(sel_q) | $past(wsel))));

    // R4: a clear write drops the ones and keeps the rest
    a_r4_clr_exact: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (sel_q == ($past(sel_q) & ~$past(wsel))));
endmodule

// File: rtl/clkmux_regbank.sv
module clkmux_regbank
    import clkmux_pkg::*;
#(
    parameter int                 NUM_MUX   = 4,
    parameter int                 SEL_W     = 3,
    parameter int                 SEL_SHIFT = 1,
    parameter int                 GATE_POS  = 7,
    parameter int                 DATA_W    = 8,
    parameter logic [NUM_MUX-1:0] HAS_UPD   = 4'b0011,
    parameter int                 ADDR_W    = $clog2(NUM_MUX * 4 + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_MUX*SEL_W-1:0] sel_active,
    output logic [NUM_MUX-1:0]       clk_en
);
    logic [NUM_MUX-1:0]             base_wr, set_wr, clr_wr, rd_base;
    logic                           upd_wr;
    logic [NUM_MUX-1:0][DATA_W-1:0] cfg_rd;
    logic [NUM_MUX-1:0]             gate;
    logic                           unused_wdata;

    assign unused_wdata = ^bus_wdata;

    clkmux_decode #(
        .NUM_MUX (NUM_MUX),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .base_wr (base_wr),
        .set_wr  (set_wr),
        .clr_wr  (clr_wr),
        .upd_wr  (upd_wr),
        .rd_base (rd_base)
    );

    for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
        clkmux_chan #(
            .SEL_W     (SEL_W),
            .SEL_SHIFT (SEL_SHIFT),
            .GATE_POS  (GATE_POS),
            .DATA_W    (DATA_W),
            .STAGED    (HAS_UPD[m])
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_base (base_wr[m]),
            .wr_set  (set_wr[m]),
            .wr_clr  (clr_wr[m]),
            .upd     (upd_wr && bus_wdata[m]),
            .wsel    (bus_wdata[SEL_SHIFT +: SEL_W]),
            .wgate   (bus_wdata[GATE_POS]),
            .cfg_rd  (cfg_rd[m]),
            .active  (sel_active[m*SEL_W +: SEL_W]),
            .gate    (gate[m])
        );
        assign clk_en[m] = ~gate[m];
    end

    always_comb begin
        bus_rdata = '0;
        for (int m = 0; m < NUM_MUX; m++) begin
            if (rd_base[m]) bus_rdata = bus_rdata | cfg_rd[m];
        end
    end

    // R11: one address reaches at most one register per cycle
    a_r11_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({base_wr, set_wr, clr_wr, upd_wr}));
endmodule

// File: tb/clkmux_regbank_bench.sv
module clkmux_regbank_bench;
    localparam int NM  = 4;
    localparam int UPD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [11:0] sel_active;
    logic [3:0]  clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_cfg [NM];
    logic [2:0] m_act [NM];

    clkmux_regbank u_clkmux_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .sel_active (sel_active),
        .clk_en     (clk_en)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model from the requirements: staged muxes are 0 and 1
    function automatic void model_sync(input int m);
        if (m >= 2) m_act[m] = m_cfg[m][3:1];
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a < UPD && a % 4 == 0) m_cfg[a/4] = d & 8'h8E;
        if (a < UPD && a % 4 == 1) m_cfg[a/4] = m_cfg[a/4] | (d & 8'h8E);
        if (a < UPD && a % 4 == 2) m_cfg[a/4] = m_cfg[a/4] & ~d;
        if (a < UPD) model_sync(a/4);
        if (a == UPD) for (int m = 0; m < 2; m++) if (d[m]) m_act[m] = m_cfg[m][3:1];
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 5'(a);
        #1 d = bus_rdata;
    endtask

    task automatic check_mux(input int m, input string req);
        logic [7:0] d;
        rd(4*m, d);
        check(req, d, m_cfg[m], $sformatf("cfg%0d", m));
        check(req, sel_active[m*3 +: 3], m_act[m], $sformatf("active%0d", m));
        check(req, clk_en[m], !m_cfg[m][7], $sformatf("clk_en%0d", m));
    endtask

    task automatic t_reset;
        for (int m = 0; m < NM; m++) begin
            m_cfg[m] = 8'h80; m_act[m] = '0;
            check_mux(m, "R1");
        end
    endtask

    task automatic t_base;
        wr(8, 8'h0A);
        check_mux(2, "R2");
        check("R8", sel_active[8:6], 5, "direct active after base write");
        wr(12, 8'hFF);
        check_mux(3, "R2");
        check("R2", m_cfg[3], 8'h8E, "model masks unused bits");
    endtask

    task automatic t_set_clr;
        wr(14, 8'hFF); check_mux(3, "R4");
        wr(13, 8'h04); check_mux(3, "R3");
        wr(13, 8'h02); check_mux(3, "R3");
        wr(14, 8'h04); check_mux(3, "R4");
        check("R4", sel_active[11:9], 1, "direct field after clear");
    endtask

    task automatic t_gate;
        wr(6, 8'h80); check_mux(1, "R5");
        check("R5", clk_en[1], 1, "enable by clear");
        wr(5, 8'h80); check_mux(1, "R5");
        check("R5", clk_en[1], 0, "disable by set");
    endtask

    task automatic t_staged;
        wr(2, 8'h0E); wr(1, 8'h0C);
        check_mux(0, "R7");
        check("R7", sel_active[2:0], 0, "staged holds before trigger");
        repeat (5) @(negedge clk);
        check("R7", sel_active[2:0], 0, "staged holds while idle");
        wr(UPD, 8'h01); check_mux(0, "R6");
        check("R6", sel_active[2:0], 6, "trigger commits");
        wr(5, 8'h06);
        wr(UPD, 8'h01); check_mux(1, "R6");
        check("R6", sel_active[5:3], 0, "zero bit leaves mux1");
        wr(UPD, 8'h02); check_mux(1, "R6");
        check("R6", sel_active[5:3], 3, "bit1 commits mux1");
        wr(UPD, 8'h0C);
        check_mux(2, "R8"); check_mux(3, "R8");
    endtask

    task automatic t_order;
        logic [7:0] d;
        wr(2, 8'h0E); wr(1, 8'h06);
        rd(0, d); check("R9", d, 8'h86, "clear then set");
        wr(UPD, 8'h01); check("R9", sel_active[2:0], 3, "clear then set commits");
        wr(9, 8'h0A); wr(10, 8'h0E);
        rd(8, d); check("R9", d, 8'h00, "set then clear");
    endtask

    task automatic t_zero_reads;
        logic [7:0] d;
        for (int m = 0; m < NM; m++)
            for (int k = 1; k < 4; k++) begin
                rd(4*m + k, d); check("R10", d, 0, $sformatf("alias read %0d", 4*m + k));
            end
        wr(UPD, 8'h0F);
        for (int a = UPD; a < 32; a++) begin
            rd(a, d); check("R10", d, 0, $sformatf("upper read %0d", a));
        end
    endtask

    task automatic t_isolation;
        wr(9, 8'hFF); wr(5, 8'h00); wr(0, 8'h02);
        for (int m = 0; m < NM; m++) check_mux(m, "R11");
        check("R11", m_cfg[2], 8'h8E, "mux2 after full set");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base();
        t_set_clr();
        t_gate();
        t_staged();
        t_order();
        t_zero_reads();
        t_isolation();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule